// File: doc/BRIEF.md
# Orthogonal Symbol Spreader with Shift-Code Expansion

This block turns a stream of bytes into a serial chip stream for the header and payload of a body-coupled link. It takes each accepted byte as two 4-bit symbols. Each symbol selects one of sixteen mutually orthogonal 16-chip codewords. Every codeword chip is then widened into an alternating shift pattern. The length of that pattern, which is the spreading factor, comes from a 3-bit rate code that is captured together with the byte.

An upstream framer offers bytes on a valid/ready handshake. A chip-timing source pulses `chip_en` once per output chip period, and the block moves on by one chip at each such pulse. While a byte is being spread, `chip_valid` is high and `chip_out` carries the current chip. `rate_err` marks a byte that was accepted with an unused rate code.

Top module: `fsc_symbol_spreader`

## Requirements
- R1: After reset, `byte_ready` is 1 and `chip_valid` and `rate_err` are 0.
- R2: Codeword chip number k, where k = 0 is sent first, for symbol value s is 1 when s AND k has an even number of set bits, and 0 otherwise. So symbol 0 gives all ones, 1 gives 1010..., 2 gives 1100..., 4 gives 11110000 twice, 8 gives eight ones and then eight zeros, 7 gives 1001011010010110 and 15 gives 1001011001101001.
- R3: The low nibble (bits 3:0) of a byte is spread before the high nibble (bits 7:4).
- R4: The rate code selects the spreading factor per codeword chip. 000 gives 64, 001 gives 32, 010 gives 16, 011 gives 8 and 100 gives 4, which is 256, 128, 64, 32 and 16 output chips per data bit.
- R5: A codeword chip of 1 is sent as 0,1,0,1,... and a codeword chip of 0 is sent as 1,0,1,0,... The pattern length equals the spreading factor.
- R6: `byte_ready` is 0 from the cycle after a byte is accepted. A byte offered in that time is not taken. `byte_ready` returns to 1 in the cycle after the `chip_en` that sends the last chip of the second symbol.
- R7: With `chip_en` at 0, `chip_out` and `chip_valid` hold their values.
- R8: Rate codes 101, 110 and 111 set `rate_err` high while that byte is spread, and the byte is spread with factor 64.
- R9: The rate code is sampled only when the byte is accepted. Changing it during spreading has no effect on that byte.
- R10: The first output chip of every byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Byte offered |
| byte_ready | output | 1 | Block can take a byte |
| byte_data | input | 8 | Byte to spread |
| rate_sel | input | 3 | Rate code, sampled with the byte |
| chip_en | input | 1 | Advance one output chip |
| chip_out | output | 1 | Current output chip |
| chip_valid | output | 1 | A byte is being spread |
| rate_err | output | 1 | Current byte carried an unused rate code |

## Verification
All sixteen symbol values are sent at the shortest spreading factor. This separates wrong codeword rows and reversed chip order, and a byte with different nibbles exposes swapped symbol order. One byte at each of the other legal rates, and at two unused codes, checks the pattern length and the fallback to factor 64. Sparse `chip_en` checks that the output holds between pulses. A changed rate code and a waiting byte held during spreading show that neither reaches the current byte.

// File: rtl/fsc_spreader_pkg.sv
package fsc_spreader_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int CW_LEN   = 16;
    localparam int POS_W    = $clog2(CW_LEN);
    localparam int RATE_W   = 3;
    localparam int SF_MAX   = 64;
    localparam int SUB_W    = $clog2(SF_MAX);

    typedef enum logic [RATE_W-1:0] {
        RATE_125K = 3'd0,
        RATE_250K = 3'd1,
        RATE_500K = 3'd2,
        RATE_1M   = 3'd3,
        RATE_2M   = 3'd4
    } rate_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        rate_e             rate;
        logic              err;
    } job_t;

    function automatic logic rate_known(logic [RATE_W-1:0] r);
        return r <= RATE_2M;
    endfunction

    // last index of the shift pattern: SF_MAX >> rate, minus one
    function automatic logic [SUB_W-1:0] sf_last(rate_e r);
        return SUB_W'((SF_MAX - 1) >> r);
    endfunction

    // orthogonal codeword: even parity of symbol AND position gives 1
    function automatic logic cw_chip(logic [NIB_W-1:0] sym, logic [POS_W-1:0] pos);
        return ~^(sym & pos);
    endfunction

endpackage

// File: rtl/fsc_spreader_job.sv
module fsc_spreader_job
    import fsc_spreader_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              done,
    output logic              start,
    output logic              busy,
    output job_t              job
);
    assign start = byte_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            job  <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            job.data <= byte_data;
            job.err  <= !rate_known(rate_sel);
            job.rate <= rate_known(rate_sel) ? rate_e'(rate_sel) : RATE_125K;
        end else if (done) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/fsc_spreader_seq.sv
module fsc_spreader_seq
    import fsc_spreader_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  logic [SUB_W-1:0] sub_last,
    output logic [SUB_W-1:0] sub,
    output logic [POS_W-1:0] pos,
    output logic             half,
    output logic             done
);
    logic sub_end;
    logic pos_end;

    assign sub_end = (sub == sub_last);
    assign pos_end = (pos == POS_W'(CW_LEN - 1));
    assign done    = step && sub_end && pos_end && half;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            sub  <= '0;
            pos  <= '0;
            half <= 1'b0;
        end else if (step) begin
            if (sub_end) begin
                sub <= '0;
                if (pos_end) begin
                    pos  <= '0;
                    half <= ~half;
                end else begin
                    pos <= pos + 1'b1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsc_spreader_chipgen.sv
module fsc_spreader_chipgen
    import fsc_spreader_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic              half,
    input  logic [POS_W-1:0]  pos,
    input  logic              sub_lsb,
    output logic              chip
);
    logic [NIB_W-1:0] sym;
    logic             cw;

    assign sym  = half ? data[BYTE_W-1:NIB_W] : data[NIB_W-1:0];
    assign cw   = cw_chip(sym, pos);
    assign chip = cw ? sub_lsb : ~sub_lsb;
endmodule

// File: rtl/fsc_symbol_spreader.sv
module fsc_symbol_spreader
    import fsc_spreader_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              chip_en,
    output logic              chip_out,
    output logic              chip_valid,
    output logic              rate_err
);
    logic             start;
    logic             busy;
    logic             done;
    job_t             job;
    logic [SUB_W-1:0] sub;
    logic [POS_W-1:0] pos;
    logic             half;
    logic             chip;

    fsc_spreader_job u_job (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .rate_sel   (rate_sel),
        .done       (done),
        .start      (start),
        .busy       (busy),
        .job        (job)
    );

    fsc_spreader_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .step     (busy && chip_en),
        .sub_last (sf_last(job.rate)),
        .sub      (sub),
        .pos      (pos),
        .half     (half),
        .done     (done)
    );

    fsc_spreader_chipgen u_gen (
        .data    (job.data),
        .half    (half),
        .pos     (pos),
        .sub_lsb (sub[0]),
        .chip    (chip)
    );

    assign byte_ready = !busy;
    assign chip_valid = busy;
    assign chip_out   = busy && chip;
    assign rate_err   = busy && job.err;
endmodule

// File: rtl/fsc_spreader_checker.sv
module fsc_spreader_checker (
    input logic       clk,
    input logic       rst,
    input logic       byte_valid,
    input logic       byte_ready,
    input logic [2:0] rate_sel,
    input logic       chip_en,
    input logic       chip_out,
    input logic       chip_valid,
    input logic       rate_err
);
    p_accept_r6: assert property (@(posedge clk) disable iff (rst)
        byte_valid && byte_ready |=> chip_valid && !byte_ready);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        chip_valid && !chip_en |=> chip_valid && $stable(chip_out));

    p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
        byte_valid && byte_ready && rate_sel > 3'd4 |=> rate_err);

    p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
        byte_valid && byte_ready && rate_sel <= 3'd4 |=> !rate_err);

    p_err_busy_r8: assert property (@(posedge clk) disable iff (rst)
        rate_err |-> chip_valid);

    p_first_zero_r10: assert property (@(posedge clk) disable iff (rst)
        byte_valid && byte_ready |=> !chip_out);
endmodule

bind fsc_symbol_spreader fsc_spreader_checker u_chk (.*);

// File: tb/fsc_symbol_spreader_tb.sv
module fsc_symbol_spreader_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic [7:0] byte_data = '0;
    logic [2:0] rate_sel = '0;
    logic       chip_en = 1'b0;
    logic       chip_out;
    logic       chip_valid;
    logic       rate_err;

    int checks = 0;
    int errors = 0;
    int en_mode = 0;
    string tag = "R1";
    bit exp_q[$];
    bit err_q[$];

    always #10 clk = ~clk;

    fsc_symbol_spreader u_dut (.*);

    function automatic logic [15:0] codeword(logic [3:0] s);
        case (s)
            4'h0: return 16'b1111111111111111;
            4'h1: return 16'b1010101010101010;
            4'h2: return 16'b1100110011001100;
            4'h3: return 16'b1001100110011001;
            4'h4: return 16'b1111000011110000;
            4'h5: return 16'b1010010110100101;
            4'h6: return 16'b1100001111000011;
            4'h7: return 16'b1001011010010110;
            4'h8: return 16'b1111111100000000;
            4'h9: return 16'b1010101001010101;
            4'hA: return 16'b1100110000110011;
            4'hB: return 16'b1001100101100110;
            4'hC: return 16'b1111000000001111;
            4'hD: return 16'b1010010101011010;
            4'hE: return 16'b1100001100111100;
            default: return 16'b1001011001101001;
        endcase
    endfunction

    task automatic push_byte(logic [7:0] d, logic [2:0] r);
        int sf;
        bit bad;
        bad = (r > 3'd4);
        case (bad ? 3'd0 : r)
            3'd0: sf = 64;
            3'd1: sf = 32;
            3'd2: sf = 16;
            3'd3: sf = 8;
            default: sf = 4;
        endcase
        for (int h = 0; h < 2; h++) begin
            logic [15:0] cw;
            cw = codeword(h == 0 ? d[3:0] : d[7:4]);
            for (int k = 15; k >= 0; k--) begin
                for (int j = 0; j < sf; j++) begin
                    exp_q.push_back(cw[k] ? bit'(j % 2) : bit'(1 - (j % 2)));
                    err_q.push_back(bad);
                end
            end
        end
    endtask

    task automatic cyc();
        chip_en = (en_mode == 0) ? 1'b1 : (($urandom % 3) == 0);
        if (chip_en && exp_q.size() > 0) begin
            void'(exp_q.pop_front());
            void'(err_q.pop_front());
        end
        if (byte_valid && byte_ready) push_byte(byte_data, rate_sel);
        @(posedge clk);
        @(negedge clk);
        begin
            bit ev, ec, ee;
            ev = exp_q.size() > 0;
            ec = ev ? exp_q[0] : 1'b0;
            ee = ev ? err_q[0] : 1'b0;
            checks++;
            if (byte_ready !== !ev || chip_valid !== ev || chip_out !== ec || rate_err !== ee) begin
                errors++;
                $display("FAIL %s: ready/valid/chip/err actual %b%b%b%b expected %b%b%b%b",
                         tag, byte_ready, chip_valid, chip_out, rate_err, !ev, ev, ec, ee);
            end
        end
    endtask

    task automatic send(logic [7:0] d, logic [2:0] r);
        bit taken;
        byte_valid = 1'b1;
        byte_data  = d;
        rate_sel   = r;
        taken = 1'b0;
        while (!taken) begin
            taken = byte_ready;
            cyc();
        end
        byte_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) cyc();
        cyc();
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        cyc();
        cyc();

        // nibble order: different low and high symbols
        tag = "R3";
        send(8'h81, 3'd4);
        drain();

        // every codeword at the shortest factor
        tag = "R2";
        for (int b = 0; b < 8; b++) begin
            send({4'(2 * b + 1), 4'(2 * b)}, 3'd4);
            drain();
        end

        // remaining legal rates and shift pattern length
        tag = "R4";
        for (int r = 0; r < 4; r++) begin
            send(8'hF7, 3'(r));
            drain();
        end
        tag = "R5";
        send(8'h0F, 3'd3);
        drain();

        // sparse chip enable
        tag = "R7";
        en_mode = 1;
        send(8'h5A, 3'd3);
        drain();
        en_mode = 0;

        // held handshake and rate change mid-byte
        tag = "R6";
        send(8'h3C, 3'd2);
        byte_valid = 1'b1;
        byte_data  = 8'hC3;
        tag = "R9";
        rate_sel   = 3'd4;
        while (exp_q.size() > 0 || !byte_ready) cyc();
        tag = "R6";
        cyc();
        byte_valid = 1'b0;
        drain();

        // unused rate codes
        tag = "R8";
        send(8'h96, 3'd5);
        drain();
        send(8'h21, 3'd7);
        drain();

        tag = "R10";
        send(8'hFF, 3'd4);
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule